// File: doc/BRIEF.md
# Dual-Rail Return-to-Spacer Word Link

This block carries an N-bit word between a sending side and a receiving side over a dual-rail code. Each data bit travels on a pair of wires, so the word is recognised from the wire code itself and no separate strobe is needed. The sending half takes a single-rail word with a valid strobe and drives the code onto the pairs. It holds the code until the receiving half acknowledges, then returns every pair to the spacer value. It accepts nothing new until the acknowledge has dropped again. That gives a four-phase sequence: data, acknowledge up, spacer, acknowledge down.

The receiving half checks each pair for a legal codeword and merges the per-bit results in a binary tree of registered C-elements. The root of the tree is the acknowledge. It goes high only when every pair carries data and goes low only when every pair has returned to spacer. The decoded word appears on a single-rail bus that does not change while the acknowledge is high. A pair with both wires high is not a legal code, and the receiver raises an error flag whenever it sees one.

Both halves are synchronous, so the link can be synthesized. The pairs leave the block on one set of ports and come back in on another. The surrounding logic, or a bench, joins them and can add skew or faults.

Top module: `dr_link`

## Requirements
- R1: A sent bit b is driven as hi=b, lo=~b on its pair. Hi=0, lo=0 is the spacer. Hi=1, lo=1 never appears on the sending side.
- R2: After reset all pairs read spacer, `tx_ready_o`=1, `rx_ack_o`=0, `rx_word_o`=0 and `rx_err_o`=0.
- R3: A word is accepted on an edge where `tx_valid_i` and `tx_ready_o` are both high, and `tx_ready_o` is low from the next cycle on. While `tx_ready_o` is low, `tx_valid_i` has no effect on the pairs.
- R4: The sending side holds the codeword unchanged until it samples `tx_ack_i` high. On the next edge it drives every pair to spacer.
- R5: After the spacer phase, `tx_ready_o` returns high only on the edge after `tx_ack_i` is sampled low. A new codeword is always preceded by spacer.
- R6: `rx_ack_o` rises exactly L=ceil(log2 N) edges after every pair holds a legal codeword, and never while any pair is still at spacer.
- R7: `rx_ack_o` falls exactly L edges after every pair is back at spacer, and stays high while any pair still holds data.
- R8: While `rx_ack_o` is high, `rx_word_o` equals the word that was sent (bit i = hi of pair i) and stays stable.
- R9: `rx_err_o` is high one edge after any pair on the receive side shows hi=1, lo=1, and low one edge after none does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_word_i | input | N | Single-rail word to send |
| tx_valid_i | input | 1 | Word offered |
| tx_ready_o | output | 1 | Sending side idle, word can be accepted |
| tx_ack_i | input | 1 | Acknowledge seen by the sending side |
| tx_hi_o | output | N | High rail of each outgoing pair |
| tx_lo_o | output | N | Low rail of each outgoing pair |
| rx_hi_i | input | N | High rail of each incoming pair |
| rx_lo_i | input | N | Low rail of each incoming pair |
| rx_ack_o | output | 1 | Completion-tree root, the acknowledge |
| rx_word_o | output | N | Decoded single-rail word |
| rx_err_o | output | 1 | Illegal both-high code seen last cycle |

## Verification
Take the accepting edge as E0, with pairs looped straight back and L = ceil(log2 N). The codeword is on the pairs after E0. The acknowledge rises after E_L, spacer appears after E_(L+1), the acknowledge falls after E_(2L+1), and ready returns after E_(2L+2). The bench samples at each falling clock edge and compares every output against these indices, computed from N. When a pair is held back or held at data, the same counts are measured from the negedge on which the hold is released. The error flag is checked one edge after a fault is applied and one edge after it is removed.

// File: rtl/dr_pkg.sv
// Shared types for the dual-rail link.
// Assumes: nothing beyond a synthesizable enum.
package dr_pkg;
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,   // waiting for a word
        TX_DATA  = 2'd1,   // codeword on the pairs, waiting for ack high
        TX_SPACE = 2'd2    // spacer on the pairs, waiting for ack low
    } tx_state_e;
endpackage

// File: rtl/dr_tx.sv
// Sending half: encodes a single-rail word onto dual-rail pairs and runs
// the four-phase sequence against the acknowledge.
// Assumes: ack_i is a registered signal from the receiving half.
module dr_tx
    import dr_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] word_i,
    input  logic         valid_i,
    output logic         ready_o,
    input  logic         ack_i,
    output logic [N-1:0] hi_o,
    output logic [N-1:0] lo_o
);
    tx_state_e    state_q;
    logic [N-1:0] hi_q;
    logic [N-1:0] lo_q;

    // Sequencer and pair registers: load code, wait ack up, spacer, wait ack down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            hi_q    <= '0;
            lo_q    <= '0;
        end else begin
            unique case (state_q)
                TX_IDLE: if (valid_i) begin
                    hi_q    <= word_i;
                    lo_q    <= ~word_i;
                    state_q <= TX_DATA;
                end
                TX_DATA: if (ack_i) begin
                    hi_q    <= '0;
                    lo_q    <= '0;
                    state_q <= TX_SPACE;
                end
                TX_SPACE: if (!ack_i) begin
                    state_q <= TX_IDLE;
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    // Outputs come straight from registers.
    assign ready_o = (state_q == TX_IDLE);
    assign hi_o    = hi_q;
    assign lo_o    = lo_q;

    // R1: the sending side never drives the illegal both-high code.
    assert_no_both_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_o & lo_o) == '0);

    // R4: a codeword on the pairs holds while the acknowledge is low.
    assert_code_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((hi_o | lo_o) != '0 && !ack_i) |=> (hi_o == $past(hi_o) && lo_o == $past(lo_o)));

    // R5: a new codeword only ever follows the spacer.
    assert_spacer_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((hi_o | lo_o) != '0 && (hi_o != $past(hi_o) || lo_o != $past(lo_o)))
            |-> (($past(hi_o) | $past(lo_o)) == '0));
endmodule

// File: rtl/dr_join.sv
// Two-input C-element, clocked model: the output moves to the common input
// value when both inputs agree and otherwise keeps its state.
// Assumes: inputs are stable around the clock edge.
module dr_join (
    input  logic clk,
    input  logic rst_n,
    input  logic a_i,
    input  logic b_i,
    output logic q_o
);
    logic q_q;

    // Rendezvous state: set on agreement high, clear on agreement low.
    always_ff @(posedge clk) begin
        if (!rst_n)                q_q <= 1'b0;
        else if (a_i && b_i)       q_q <= 1'b1;
        else if (!a_i && !b_i)     q_q <= 1'b0;
    end

    assign q_o = q_q;

    // R6, R7: the output only changes towards a value both inputs shared.
    assert_join_agree_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o != $past(q_o)) |-> ($past(a_i) == $past(b_i) && q_o == $past(a_i)));
endmodule

// File: rtl/dr_cmp_tree.sv
// Completion tree: a binary heap of clocked C-elements over per-pair
// "holds data" flags. Latency is ceil(log2 N) edges in both directions.
// Assumes: N >= 2. Unused leaves when N is not a power of two mirror leaf 0.
module dr_cmp_tree #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] leaf_i,
    output logic         root_o
);
    localparam int LEVELS = $clog2(N);
    localparam int P      = 1 << LEVELS;
    localparam int NODES  = 2 * P - 1;

    logic [NODES-1:0] node;

    // Leaves sit at heap positions P-1 .. 2P-2.
    for (genvar j = 0; j < P; j++) begin : g_leaf
        if (j < N) begin : g_real
            assign node[P-1+j] = leaf_i[j];
        end else begin : g_pad
            assign node[P-1+j] = leaf_i[0];
        end
    end

    // Internal nodes: each joins its two children.
    for (genvar i = 0; i < P - 1; i++) begin : g_node
        dr_join u_join (
            .clk  (clk),
            .rst_n(rst_n),
            .a_i  (node[2*i+1]),
            .b_i  (node[2*i+2]),
            .q_o  (node[i])
        );
    end

    assign root_o = node[0];
endmodule

// File: rtl/dr_rx.sv
// Receiving half: classifies each pair, runs the completion tree, captures
// the decoded word, and flags illegal codes.
// Assumes: pairs change only at clock edges (synchronous model).
module dr_rx #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hi_i,
    input  logic [N-1:0] lo_i,
    output logic         ack_o,
    output logic [N-1:0] word_o,
    output logic         err_o
);
    logic [N-1:0] has_data;
    logic [N-1:0] bad_pair;
    logic         all_data;
    logic [N-1:0] word_q;
    logic         err_q;

    // Per-pair classification: data when exactly one rail is high.
    for (genvar i = 0; i < N; i++) begin : g_pair
        assign has_data[i] = hi_i[i] ^ lo_i[i];
        assign bad_pair[i] = hi_i[i] & lo_i[i];
    end
    assign all_data = &has_data;

    dr_cmp_tree #(.N(N)) u_tree (
        .clk   (clk),
        .rst_n (rst_n),
        .leaf_i(has_data),
        .root_o(ack_o)
    );

    // Word capture: load only a complete word, and only while ack is low.
    always_ff @(posedge clk) begin
        if (!rst_n)                  word_q <= '0;
        else if (all_data && !ack_o) word_q <= hi_i;
    end

    // Illegal-code flag, one edge behind the pairs.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= |bad_pair;
    end

    assign word_o = word_q;
    assign err_o  = err_q;

    // R8: the delivered word does not move while the acknowledge stays high.
    assert_word_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && $past(ack_o)) |-> $stable(word_o));

    // R9: a both-high pair is reported on the next edge.
    assert_err_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((hi_i & lo_i) != '0) |=> err_o);

    // R6: the acknowledge never rises while the previous cycle had a spacer
    // pair, since the tree is at least one register deep.
    assert_no_early_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(all_data));
endmodule

// File: rtl/dr_link.sv
// Dual-rail link top: sending and receiving halves side by side. The
// pairs leave on tx_* and return on rx_*, joined outside the block.
// Assumes: tx_ack_i is fed from rx_ack_o, directly or through registers.
module dr_link #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] tx_word_i,
    input  logic         tx_valid_i,
    output logic         tx_ready_o,
    input  logic         tx_ack_i,
    output logic [N-1:0] tx_hi_o,
    output logic [N-1:0] tx_lo_o,
    input  logic [N-1:0] rx_hi_i,
    input  logic [N-1:0] rx_lo_i,
    output logic         rx_ack_o,
    output logic [N-1:0] rx_word_o,
    output logic         rx_err_o
);
    dr_tx #(.N(N)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_i (tx_word_i),
        .valid_i(tx_valid_i),
        .ready_o(tx_ready_o),
        .ack_i  (tx_ack_i),
        .hi_o   (tx_hi_o),
        .lo_o   (tx_lo_o)
    );

    dr_rx #(.N(N)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .hi_i  (rx_hi_i),
        .lo_i  (rx_lo_i),
        .ack_o (rx_ack_o),
        .word_o(rx_word_o),
        .err_o (rx_err_o)
    );
endmodule

// File: tb/sim_dr_link.sv
module sim_dr_link;
    localparam int N = 8;
    localparam int L = $clog2(N);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] tx_word = '0;
    logic         tx_valid = 1'b0;
    logic         tx_ready, rx_ack, rx_err;
    logic [N-1:0] tx_hi, tx_lo, rx_hi, rx_lo, rx_word;
    logic [N-1:0] frz = '0, fz_hi = '0, fz_lo = '0, frc = '0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    // Channel model: per-pair freeze to a held value, plus forced both-high.
    assign rx_hi = ((frz & fz_hi) | (~frz & tx_hi)) | frc;
    assign rx_lo = ((frz & fz_lo) | (~frz & tx_lo)) | frc;

    dr_link #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n),
        .tx_word_i(tx_word), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
        .tx_ack_i(rx_ack), .tx_hi_o(tx_hi), .tx_lo_o(tx_lo),
        .rx_hi_i(rx_hi), .rx_lo_i(rx_lo),
        .rx_ack_o(rx_ack), .rx_word_o(rx_word), .rx_err_o(rx_err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        chk(tx_hi == '0 && tx_lo == '0, "R2 pairs spacer", {tx_hi, tx_lo}, 0);
        chk(tx_ready == 1'b1, "R2 ready", tx_ready, 1);
        chk(rx_ack == 1'b0, "R2 ack", rx_ack, 0);
        chk(rx_word == '0, "R2 word", rx_word, 0);
        chk(rx_err == 1'b0, "R2 err", rx_err, 0);
    endtask

    // Full transfer with straight loopback, plus a busy-time valid at n=0.
    task automatic t_send(input logic [N-1:0] w, input logic [N-1:0] w_busy);
        @(negedge clk);
        tx_word = w; tx_valid = 1'b1;
        @(posedge clk);                  // E0, accepted
        @(negedge clk);
        chk(tx_hi == w && tx_lo == ~w, "R1 encode", {tx_hi, tx_lo}, {w, ~w});
        chk(tx_ready == 1'b0, "R3 ready low", tx_ready, 0);
        tx_word = w_busy;                // valid still high while busy
        for (int n = 1; n <= 2 * L + 3; n++) begin
            @(negedge clk);
            if (n == 1) begin
                chk(tx_hi == w && tx_lo == ~w, "R3 busy valid ignored", tx_hi, w);
                tx_valid = 1'b0;
            end
            chk(rx_ack == (n >= L && n <= 2 * L), "R6 R7 ack timing", rx_ack, (n >= L && n <= 2 * L));
            if (n <= L)
                chk(tx_hi == w && tx_lo == ~w, "R4 code held", tx_hi, w);
            else
                chk(tx_hi == '0 && tx_lo == '0, "R4 spacer", {tx_hi, tx_lo}, 0);
            chk(tx_ready == (n >= 2 * L + 2), "R5 ready return", tx_ready, (n >= 2 * L + 2));
            if (n >= L && n <= 2 * L)
                chk(rx_word == w, "R8 word", rx_word, w);
        end
    endtask

    // Skewed pairs: some held at spacer on arrival, some held at data on return.
    task automatic t_skew(input logic [N-1:0] w, input logic [N-1:0] late, input logic [N-1:0] sticky);
        @(negedge clk);
        frz = late; fz_hi = '0; fz_lo = '0;
        tx_word = w; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (10) @(negedge clk);
        chk(rx_ack == 1'b0, "R6 no ack with spacer pair", rx_ack, 0);
        chk(tx_hi == w, "R4 code held while no ack", tx_hi, w);
        frz = '0;                        // release late pairs
        for (int n = 1; n <= L; n++) begin
            @(negedge clk);
            chk(rx_ack == (n == L), "R6 ack after release", rx_ack, (n == L));
        end
        fz_hi = tx_hi; fz_lo = tx_lo; frz = sticky;   // hold some pairs at data
        repeat (8) @(negedge clk);
        chk(tx_hi == '0 && tx_lo == '0, "R4 spacer sent", {tx_hi, tx_lo}, 0);
        chk(rx_ack == 1'b1, "R7 ack held by data pair", rx_ack, 1);
        chk(rx_word == w, "R8 word stable", rx_word, w);
        chk(tx_ready == 1'b0, "R5 not ready while ack high", tx_ready, 0);
        frz = '0;
        for (int n = 1; n <= L + 1; n++) begin
            @(negedge clk);
            if (n <= L) chk(rx_ack == (n < L), "R7 ack fall", rx_ack, (n < L));
            chk(tx_ready == (n == L + 1), "R5 ready after ack low", tx_ready, (n == L + 1));
        end
    endtask

    task automatic t_illegal(input logic [N-1:0] m);
        @(negedge clk);
        chk(rx_err == 1'b0, "R9 err idle", rx_err, 0);
        frc = m;
        @(negedge clk);
        chk(rx_err == 1'b1, "R9 err raised", rx_err, 1);
        chk(rx_ack == 1'b0, "R6 illegal is not data", rx_ack, 0);
        frc = '0;
        @(negedge clk);
        chk(rx_err == 1'b0, "R9 err cleared", rx_err, 0);
    endtask

    initial begin
        t_reset();
        t_send(8'hA5, 8'h3C);
        t_send(8'h00, 8'hFF);
        t_send(8'hFF, 8'h00);
        t_skew(8'h69, 8'h81, 8'h10);
        t_illegal(8'h04);
        t_send(8'h1E, 8'h77);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule